// File: doc/BRIEF.md
# Multi-Level Translation Table Walker

This block turns a 48-bit virtual address into a physical address by reading descriptors from a translation table tree held in memory, one level at a time. Each request carries the virtual address, the root table base, a granule select (4 KB or 16 KB pages) and an input-size field. The input-size field sets how wide the virtual address space is, and so at which of the four levels the walk begins. Levels above the starting level are never read.

Descriptors are fetched one at a time over a plain read port: a one-cycle read strobe with an address, then a response strobe with the 64-bit word. A walk stops at a block descriptor on an intermediate level, at a page descriptor on the last level, or at the first fault. The result is a physical address, or a fault flag with a 6-bit status code. The code's upper bits give the fault class and its low two bits give the level. A faulting request also returns its virtual address. Only one walk runs at a time, and a new request is accepted only while the walker is idle.

Top module: `xlat_walker`

## Requirements
- R1: With the 4 KB granule, the level 0, 1, 2 and 3 indices are VA[47:39], VA[38:30], VA[29:21] and VA[20:12]. Each descriptor read address is the table base with its low 12 bits cleared, plus index*8, so every read address is 8-byte aligned.
- R2: With the 16 KB granule, the level 0 index is VA[47] and the level 1, 2 and 3 indices are VA[46:36], VA[35:25] and VA[24:14]. The table base has its low 14 bits cleared before index*8 is added.
- R3: The VA width is 64 minus the input-size field, after the field is clamped to the range 16..39. The walk starts at the highest level that the bits above the page offset (12 or 14 bits) still reach: for example level 0 at width 48, level 2 for 4 KB at width 30, and level 1 for 16 KB at width 47. Levels above the start are not read.
- R4: A VA with any bit set at or above the VA width faults with code 0x04 and issues no memory read.
- R5: Descriptor bits [1:0] are decoded as follows. If bit 0 is 0 the descriptor is invalid. The value 11 is a table at levels 0 to 2 and a page at level 3. The value 01 is a block at levels 1 and 2. An invalid descriptor, or 01 at level 0 or level 3, gives a translation fault with code 0x04 plus the level.
- R6: If any descriptor output-address bit in [47:OA_W] is set, the walk gives an address-size fault with code 0x00 plus the level. This applies to tables, blocks and pages. The next table base is taken from descriptor bits [47:granule shift].
- R7: A block or page with access bit 10 clear gives code 0x08 plus the level.
- R8: An unprivileged request that reaches a block or page with bit 6 clear gives code 0x0C plus the level. When several checks fail, the address-size fault wins over the access fault, which wins over the permission fault.
- R9: A successful walk returns the leaf output address above the level's shift and the VA bits below it. The shift is 12, 21 or 30 for the 4 KB granule (levels 3, 2, 1), and 14, 25 or 36 for the 16 KB granule.
- R10: `req_ready` is high only while idle, and at most one read is outstanding. `mem_rsp_valid` while no read is pending has no effect. `done` pulses for one cycle. The result outputs change only together with `done` and are held until the next `done`. A success shows fault 0, code 0 and fault address 0.
- R11: After reset, `req_ready` is 1, and `done`, `fault`, `mem_rd_valid` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 48 | Virtual address |
| req_base | input | 48 | Root table base |
| req_gran16 | input | 1 | 1 = 16 KB granule, 0 = 4 KB |
| req_tsz | input | 6 | Input-size field (VA width = 64 - value) |
| req_unpriv | input | 1 | Unprivileged access |
| mem_rd_valid | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | 48 | Descriptor address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Descriptor word |
| done | output | 1 | Result pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 6 | {class, level} status |
| res_pa | output | 48 | Physical address |
| fault_addr | output | 48 | VA of a faulting request |

## Verification
The bench builds the walker with both granules enabled, OA_W at 40 and the input-size clamp at 16..39. This lets it drive input-size values beyond both clamp ends and place address-size faults in descriptor bits 47..40. Because the 16 KB variant is present, every start level from 0 to 3 can be reached, and blocks of every size as well as one-bit level 0 indices are covered. Random response latency and fault injection at each level test the ordering of the fault checks against an independent walk model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int unsigned LVL_N    = 4;
   localparam int unsigned G4_OFF   = 12;
   localparam int unsigned G4_BPL   = 9;
   localparam int unsigned G16_OFF  = 14;
   localparam int unsigned G16_BPL  = 11;
   localparam int unsigned IDX_W    = G16_BPL;

   typedef logic [1:0] lvl_t;

   typedef enum logic [1:0] {
      FC_ASIZE  = 2'd0,
      FC_XLAT   = 2'd1,
      FC_ACCESS = 2'd2,
      FC_PERM   = 2'd3
   } fclass_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } wstate_e;

   typedef enum logic [1:0] {
      EV_NEXT  = 2'd0,
      EV_LEAF  = 2'd1,
      EV_FAULT = 2'd2
   } devent_e;

   // bit position of the lowest VA bit indexed at a level
   function automatic logic [5:0] lvl_shift(input lvl_t l, input logic g16);
      int unsigned up;
      up = 3 - int'(l);
      if (g16) lvl_shift = 6'(G16_OFF + G16_BPL * up);
      else     lvl_shift = 6'(G4_OFF + G4_BPL * up);
   endfunction

   function automatic logic [5:0] mk_code(input fclass_e c, input lvl_t l);
      mk_code = {2'b00, c, l};
   endfunction

endpackage

// File: rtl/xlat_level_map.sv
module xlat_level_map
   import xlat_pkg::*;
#(
   parameter int unsigned TSZ_W   = 6,
   parameter int unsigned TSZ_MIN = 16,
   parameter int unsigned TSZ_MAX = 39
) (
   input  logic             g16,
   input  logic [TSZ_W-1:0] tsz,
   output lvl_t             start_lvl,
   output logic [6:0]       va_bits
);

   always_comb begin
      int unsigned t;
      int          rem;
      int          bpl;
      t = 32'(tsz);
      if (t < TSZ_MIN)      t = TSZ_MIN;
      else if (t > TSZ_MAX) t = TSZ_MAX;
      va_bits = 7'(64 - t);
      rem = int'(va_bits) - (g16 ? int'(G16_OFF) : int'(G4_OFF));
      bpl = g16 ? int'(G16_BPL) : int'(G4_BPL);
      start_lvl = 2'd3;
      // the deepest level count that still covers the remaining bits wins
      for (int k = 1; k < int'(LVL_N); k++) begin
         if (rem > bpl * k) start_lvl = lvl_t'(3 - k);
      end
   end

endmodule

// File: rtl/xlat_index_slice.sv
module xlat_index_slice
   import xlat_pkg::*;
#(
   parameter int unsigned VA_W = 48
) (
   input  logic [VA_W-1:0] va,
   input  logic [VA_W-1:0] tbl_base,
   input  lvl_t            lvl,
   input  logic            g16,
   output logic [VA_W-1:0] desc_addr
);

   localparam logic [IDX_W-1:0] MASK4  = IDX_W'((1 << G4_BPL) - 1);
   localparam logic [IDX_W-1:0] MASK16 = IDX_W'((1 << G16_BPL) - 1);
   localparam logic [VA_W-1:0]  GM4    = VA_W'((1 << G4_OFF) - 1);
   localparam logic [VA_W-1:0]  GM16   = VA_W'((1 << G16_OFF) - 1);

   logic [5:0]       sh;
   logic [IDX_W-1:0] idx;
   logic [VA_W-1:0]  aligned;

   always_comb begin
      sh        = lvl_shift(lvl, g16);
      idx       = IDX_W'(va >> sh) & (g16 ? MASK16 : MASK4);
      aligned   = tbl_base & ~(g16 ? GM16 : GM4);
      desc_addr = aligned + (VA_W'(idx) << 3);
   end

endmodule

// File: rtl/xlat_desc_eval.sv
module xlat_desc_eval
   import xlat_pkg::*;
#(
   parameter int unsigned VA_W   = 48,
   parameter int unsigned OA_W   = 40,
   parameter int unsigned DESC_W = 64
) (
   input  logic [DESC_W-1:0] desc,
   input  lvl_t              lvl,
   input  logic              g16,
   input  logic              unpriv,
   input  logic [VA_W-1:0]   va,
   output devent_e           ev,
   output logic [5:0]        code,
   output logic [VA_W-1:0]   next_base,
   output logic [VA_W-1:0]   leaf_pa
);

   localparam int unsigned AF_BIT  = 10;
   localparam int unsigned USR_BIT = 6;
   localparam logic [VA_W-1:0] GM4  = VA_W'((1 << G4_OFF) - 1);
   localparam logic [VA_W-1:0] GM16 = VA_W'((1 << G16_OFF) - 1);

   logic [VA_W-1:0] oa;
   logic [VA_W-1:0] smask;
   logic            oa_wide;
   logic            is_last;
   logic            blk_ok;
   logic            unused_hi;

   assign unused_hi = ^desc[DESC_W-1:VA_W];

   always_comb begin
      oa        = desc[VA_W-1:0];
      smask     = (VA_W'(1) << lvl_shift(lvl, g16)) - VA_W'(1);
      oa_wide   = |oa[VA_W-1:OA_W];
      is_last   = (lvl == 2'd3);
      blk_ok    = (lvl == 2'd1) || (lvl == 2'd2);
      next_base = oa & ~(g16 ? GM16 : GM4);
      leaf_pa   = (oa & ~smask) | (va & smask);
      ev        = EV_FAULT;
      code      = mk_code(FC_XLAT, lvl);
      if (!desc[0]) begin
         code = mk_code(FC_XLAT, lvl);
      end else if (!desc[1] && !blk_ok) begin
         code = mk_code(FC_XLAT, lvl);
      end else if (oa_wide) begin
         code = mk_code(FC_ASIZE, lvl);
      end else if (desc[1] && !is_last) begin
         ev   = EV_NEXT;
         code = '0;
      end else if (!desc[AF_BIT]) begin
         code = mk_code(FC_ACCESS, lvl);
      end else if (unpriv && !desc[USR_BIT]) begin
         code = mk_code(FC_PERM, lvl);
      end else begin
         ev   = EV_LEAF;
         code = '0;
      end
   end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int unsigned VA_W      = 48,
   parameter int unsigned OA_W      = 40,
   parameter int unsigned DESC_W    = 64,
   parameter int unsigned TSZ_W     = 6,
   parameter int unsigned TSZ_MIN   = 16,
   parameter int unsigned TSZ_MAX   = 39,
   parameter bit          GRAN16_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   input  logic [VA_W-1:0]   req_base,
   input  logic              req_gran16,
   input  logic [TSZ_W-1:0]  req_tsz,
   input  logic              req_unpriv,
   output logic              mem_rd_valid,
   output logic [VA_W-1:0]   mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [DESC_W-1:0] mem_rsp_data,
   output logic              done,
   output logic              fault,
   output logic [5:0]        fault_code,
   output logic [VA_W-1:0]   res_pa,
   output logic [VA_W-1:0]   fault_addr
);

   if (VA_W != 48) begin : g_bad_va
      $error("xlat_walker: VA_W must be 48");
   end
   if (OA_W >= VA_W || OA_W < 32) begin : g_bad_oa
      $error("xlat_walker: OA_W must lie in 32..VA_W-1");
   end
   if (DESC_W < VA_W) begin : g_bad_desc
      $error("xlat_walker: DESC_W narrower than VA_W");
   end
   if (TSZ_MIN < 16 || TSZ_MAX > 39 || TSZ_MIN > TSZ_MAX) begin : g_bad_tsz
      $error("xlat_walker: size clamp outside 16..39");
   end
   if (TSZ_W < 6) begin : g_bad_tszw
      $error("xlat_walker: TSZ_W must hold 63");
   end

   wstate_e         st_q;
   lvl_t            lvl_q;
   logic [VA_W-1:0] tbl_q;
   logic [VA_W-1:0] va_q;
   logic            g16_q;
   logic            unpriv_q;

   logic            done_q;
   logic            fault_q;
   logic [5:0]      code_q;
   logic [VA_W-1:0] pa_q;
   logic [VA_W-1:0] faddr_q;

   logic            g16_in;
   lvl_t            start_lvl;
   logic [6:0]      va_bits;
   logic            va_out_of_range;

   devent_e         ev;
   logic [5:0]      ev_code;
   logic [VA_W-1:0] next_base;
   logic [VA_W-1:0] leaf_pa;
   logic [VA_W-1:0] rd_addr;

   if (GRAN16_EN) begin : g_gran_both
      assign g16_in = req_gran16;
   end else begin : g_gran_4k
      logic unused_gran;
      assign unused_gran = req_gran16;
      assign g16_in      = 1'b0;
   end

   xlat_level_map #(
      .TSZ_W  (TSZ_W),
      .TSZ_MIN(TSZ_MIN),
      .TSZ_MAX(TSZ_MAX)
   ) u_lvl_map (
      .g16      (g16_in),
      .tsz      (req_tsz),
      .start_lvl(start_lvl),
      .va_bits  (va_bits)
   );

   assign va_out_of_range = |(req_va >> va_bits);

   xlat_index_slice #(
      .VA_W(VA_W)
   ) u_slice (
      .va       (va_q),
      .tbl_base (tbl_q),
      .lvl      (lvl_q),
      .g16      (g16_q),
      .desc_addr(rd_addr)
   );

   xlat_desc_eval #(
      .VA_W  (VA_W),
      .OA_W  (OA_W),
      .DESC_W(DESC_W)
   ) u_eval (
      .desc     (mem_rsp_data),
      .lvl      (lvl_q),
      .g16      (g16_q),
      .unpriv   (unpriv_q),
      .va       (va_q),
      .ev       (ev),
      .code     (ev_code),
      .next_base(next_base),
      .leaf_pa  (leaf_pa)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         lvl_q    <= '0;
         tbl_q    <= '0;
         va_q     <= '0;
         g16_q    <= 1'b0;
         unpriv_q <= 1'b0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         code_q   <= '0;
         pa_q     <= '0;
         faddr_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q     <= req_va;
                  tbl_q    <= req_base;
                  g16_q    <= g16_in;
                  unpriv_q <= req_unpriv;
                  lvl_q    <= start_lvl;
                  if (va_out_of_range) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     code_q  <= mk_code(FC_XLAT, 2'd0);
                     pa_q    <= '0;
                     faddr_q <= req_va;
                  end else begin
                     st_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  unique case (ev)
                     EV_NEXT: begin
                        tbl_q <= next_base;
                        lvl_q <= lvl_q + 2'd1;
                        st_q  <= ST_ISSUE;
                     end
                     EV_LEAF: begin
                        st_q    <= ST_IDLE;
                        done_q  <= 1'b1;
                        fault_q <= 1'b0;
                        code_q  <= '0;
                        pa_q    <= leaf_pa;
                        faddr_q <= '0;
                     end
                     default: begin
                        st_q    <= ST_IDLE;
                        done_q  <= 1'b1;
                        fault_q <= 1'b1;
                        code_q  <= ev_code;
                        pa_q    <= '0;
                        faddr_q <= va_q;
                     end
                  endcase
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (st_q == ST_IDLE);
   assign mem_rd_valid = (st_q == ST_ISSUE);
   assign mem_rd_addr  = rd_addr;
   assign done         = done_q;
   assign fault        = fault_q;
   assign fault_code   = code_q;
   assign res_pa       = pa_q;
   assign fault_addr   = faddr_q;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int unsigned VA_W = 48
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            mem_rd_valid,
   input logic [VA_W-1:0] mem_rd_addr,
   input logic            done,
   input logic            fault,
   input logic [5:0]      fault_code,
   input logic [VA_W-1:0] res_pa,
   input logic [VA_W-1:0] fault_addr
);

   // R10
   rd_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);

   // R10
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(res_pa) && $stable(fault) && $stable(fault_code)
                 && $stable(fault_addr)));

   // R1
   rd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr[2:0] == 3'b000));

   // R10
   success_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> (fault_code == 6'd0 && fault_addr == '0));

endmodule

bind xlat_walker xlat_walker_chk #(
   .VA_W(VA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .mem_rd_valid(mem_rd_valid),
   .mem_rd_addr (mem_rd_addr),
   .done        (done),
   .fault       (fault),
   .fault_code  (fault_code),
   .res_pa      (res_pa),
   .fault_addr  (fault_addr)
);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;

   localparam int CLK_PERIOD = 10;
   localparam int OA_B       = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [47:0] req_va = '0;
   logic [47:0] req_base = '0;
   logic        req_gran16 = 1'b0;
   logic [5:0]  req_tsz = 6'd16;
   logic        req_unpriv = 1'b0;
   logic        mem_rd_valid;
   logic [47:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done;
   logic        fault;
   logic [5:0]  fault_code;
   logic [47:0] res_pa;
   logic [47:0] fault_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_walker #(
      .VA_W(48), .OA_W(OA_B), .DESC_W(64), .TSZ_W(6),
      .TSZ_MIN(16), .TSZ_MAX(39), .GRAN16_EN(1'b1)
   ) u_xlat_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_base(req_base), .req_gran16(req_gran16),
      .req_tsz(req_tsz), .req_unpriv(req_unpriv),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .fault(fault), .fault_code(fault_code),
      .res_pa(res_pa), .fault_addr(fault_addr)
   );

   logic [63:0] mem [logic [47:0]];
   logic [47:0] rd_log [$];
   logic [47:0] exp_rd [$];
   bit          inject_spur = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   bit          e_fault;
   logic [5:0]  e_code;
   logic [47:0] e_pa;
   bit          e_oor;

   task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic int clampt(input int t);
      return (t < 16) ? 16 : ((t > 39) ? 39 : t);
   endfunction

   function automatic int f_start(input bit g, input int t);
      int w, off, bpl, n;
      w   = 64 - clampt(t);
      off = g ? 14 : 12;
      bpl = g ? 11 : 9;
      n   = (w - off + bpl - 1) / bpl;
      return 4 - n;
   endfunction

   function automatic int f_shift(input int lvl, input bit g);
      return g ? (14 + 11 * (3 - lvl)) : (12 + 9 * (3 - lvl));
   endfunction

   function automatic logic [47:0] f_daddr(input logic [47:0] tbl,
      input logic [47:0] va, input int lvl, input bit g);
      int          off, bpl;
      logic [47:0] idx;
      off = g ? 14 : 12;
      bpl = g ? 11 : 9;
      idx = (va >> f_shift(lvl, g)) & ((48'd1 << bpl) - 48'd1);
      return (tbl & ~((48'd1 << off) - 48'd1)) + (idx << 3);
   endfunction

   function automatic logic [63:0] rd_mem(input logic [47:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   // independent walk model
   task automatic ref_walk(input logic [47:0] va, input logic [47:0] base,
                           input bit g, input int t, input bit un);
      int          w, lvl;
      logic [47:0] tbl, a, sm;
      logic [63:0] d;
      bit          fin;
      exp_rd.delete();
      e_fault = 0; e_code = 0; e_pa = 0; e_oor = 0;
      w = 64 - clampt(t);
      if (w < 48 && (va >> w) != 0) begin
         e_oor = 1; e_fault = 1; e_code = 6'h04;
         return;
      end
      lvl = f_start(g, t);
      tbl = base;
      fin = 0;
      while (!fin) begin
         a = f_daddr(tbl, va, lvl, g);
         exp_rd.push_back(a);
         d = rd_mem(a);
         fin = 1;
         if (!d[0] || (!d[1] && (lvl == 0 || lvl == 3))) begin
            e_fault = 1; e_code = 6'(4 + lvl);
         end else if (d[47:OA_B] != 0) begin
            e_fault = 1; e_code = 6'(lvl);
         end else if (d[1] && lvl < 3) begin
            tbl = d[47:0] & ~((48'd1 << (g ? 14 : 12)) - 48'd1);
            lvl++;
            fin = 0;
         end else if (!d[10]) begin
            e_fault = 1; e_code = 6'(8 + lvl);
         end else if (un && !d[6]) begin
            e_fault = 1; e_code = 6'(12 + lvl);
         end else begin
            sm   = (48'd1 << f_shift(lvl, g)) - 48'd1;
            e_pa = (d[47:0] & ~sm) | (va & sm);
         end
      end
   endtask

   // memory responder
   initial begin
      logic [47:0] a;
      forever begin
         @(negedge clk);
         if (inject_spur && !mem_rd_valid) begin
            mem_rsp_data  = 64'hFFFF_FFFF_FFFF_FFFF;
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
         while (rst_n && mem_rd_valid) begin
            a = mem_rd_addr;
            rd_log.push_back(a);
            repeat (1 + $urandom_range(0, 2)) @(negedge clk);
            mem_rsp_data  = rd_mem(a);
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   task automatic run_walk(input logic [47:0] va, input logic [47:0] base,
      input bit g, input int t, input bit un, input string rq);
      int cyc;
      ref_walk(va, base, g, t, un);
      rd_log.delete();
      @(negedge clk);
      req_va = va; req_base = base; req_gran16 = g;
      req_tsz = 6'(t); req_unpriv = un; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (!e_oor) chk(req_ready == 1'b0, "R10 busy", 64'(req_ready), 64'd0);
      cyc = 0;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      chk(done == 1'b1, {rq, " done"}, 64'(done), 64'd1);
      chk(fault == e_fault, {rq, " fault"}, 64'(fault), 64'(e_fault));
      chk(fault_code == e_code, {rq, " code"}, 64'(fault_code), 64'(e_code));
      if (e_fault)
         chk(fault_addr == va, {rq, " R4 fault_addr"}, 64'(fault_addr), 64'(va));
      else
         chk(res_pa == e_pa, {rq, " R9 pa"}, 64'(res_pa), 64'(e_pa));
      chk(rd_log.size() == exp_rd.size(), {rq, " read count"},
          64'(rd_log.size()), 64'(exp_rd.size()));
      for (int i = 0; i < exp_rd.size() && i < rd_log.size(); i++)
         chk(rd_log[i] == exp_rd[i], {rq, " read addr"}, 64'(rd_log[i]),
             64'(exp_rd[i]));
      chk(req_ready == 1'b1, "R10 ready after done", 64'(req_ready), 64'd1);
      @(negedge clk);
      chk(done == 1'b0, "R10 done pulse", 64'(done), 64'd0);
   endtask

   // random tree along the path of one VA
   task automatic gen_trial();
      bit          g, un;
      int          t, w, lvl, r;
      logic [47:0] va, base, a, nb;
      logic [63:0] d;
      g  = 1'($urandom_range(0, 1));
      un = 1'($urandom_range(0, 1));
      t  = $urandom_range(12, 42);
      w  = 64 - clampt(t);
      va = {$urandom, $urandom};
      va = va & ((48'd1 << w) - 48'd1);
      if (w < 48 && $urandom_range(0, 9) == 0) va[$urandom_range(w, 47)] = 1'b1;
      base = {8'h0, $urandom, 8'h0} ^ 48'($urandom_range(0, 'h3FFF));
      mem.delete();
      lvl = f_start(g, t);
      nb  = base;
      for (int s = 0; s < 4; s++) begin
         a = f_daddr(nb, va, lvl, g);
         d = {16'h0, 8'h0, $urandom, 8'($urandom)};
         r = $urandom_range(0, 99);
         if (lvl < 3 && r < 60) begin
            d[1:0] = 2'b11;
            if ($urandom_range(0, 19) == 0) d[47:40] = 8'($urandom_range(1, 255));
            mem[a] = d;
            nb = d[47:0];
            lvl++;
         end else begin
            r = $urandom_range(0, 99);
            d[1:0] = (lvl == 3) ? 2'b11 : 2'b01;
            if (r < 10)      d[0] = 1'b0;
            else if (r < 20) d[1] = ~d[1];
            d[10] = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 12) == 0) d[47:40] = 8'($urandom_range(1, 255));
            mem[a] = d;
            break;
         end
      end
      run_walk(va, base, g, t, un, "R5 random");
   endtask

   task automatic chain4k(input logic [47:0] base, input logic [63:0] leaf);
      mem.delete();
      mem[base]            = 64'h4000_1003;
      mem[base + 48'h1010] = 64'h4000_2003;
      mem[48'h4000_2000]   = 64'h4000_3003;
      mem[48'h4000_3000]   = leaf;
   endtask

   initial begin
      int cyc;
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'd1);
      chk(done == 1'b0 && fault == 1'b0, "R11 done/fault", 64'({done, fault}), 64'd0);
      chk(mem_rd_valid == 1'b0, "R11 rd", 64'(mem_rd_valid), 64'd0);
      chk(res_pa == '0 && fault_code == '0, "R11 results", 64'(res_pa), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 4 KB full walk, VA 0x80000000 -> PA 0x90000000
      chain4k(48'h4000_0000, 64'h9000_0443);
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b0, "R1 4k page");
      chk(res_pa == 48'h9000_0000, "R1 pa", 64'(res_pa), 64'h9000_0000);
      chk(rd_log.size() > 1 && rd_log[1] == 48'h4000_1010, "R1 L1 idx2",
          64'(rd_log.size() > 1 ? rd_log[1] : 48'd0), 64'h4000_1010);

      // R3 input-size below clamp acts as 16
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 8, 1'b0, "R3 clamp low");

      // R3 30-bit space starts at level 2
      mem.delete();
      mem[48'h5000_0800] = 64'h5000_1003;
      mem[48'h5000_1028] = 64'h7777_7443;
      run_walk(48'h2000_5123, 48'h5000_0000, 1'b0, 34, 1'b0, "R3 start L2");
      chk(res_pa == 48'h7777_7123, "R3 pa", 64'(res_pa), 64'h7777_7123);
      chk(rd_log.size() == 2, "R3 two reads", 64'(rd_log.size()), 64'd2);

      // R4 VA above width
      run_walk(48'h4000_0000, 48'h5000_0000, 1'b0, 34, 1'b0, "R4 oor");
      chk(rd_log.size() == 0 && fault_code == 6'h04, "R4 no read",
          64'(rd_log.size()), 64'd0);

      // R2 16 KB: level 0 uses VA[47], level 1 block
      mem.delete();
      mem[48'h6000_0008] = 64'h6000_4003;
      mem[48'h6000_4008] = 64'h10_0000_0401;
      run_walk(48'h8010_0000_1234, 48'h6000_0000, 1'b1, 16, 1'b0, "R2 16k");
      chk(res_pa == 48'h10_0000_1234, "R2 pa", 64'(res_pa), 64'h10_0000_1234);

      // R3 16 KB 47-bit space starts at level 1
      run_walk(48'h0010_0000_0042, 48'h6000_0000, 1'b1, 17, 1'b0, "R3 16k L1");

      // R7 block with access bit clear at level 1 -> 0x9
      mem.delete();
      mem[48'h4000_0000] = 64'h4000_1003;
      mem[48'h4000_1010] = 64'h8000_0001;
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b0, "R7 af");
      chk(fault_code == 6'h09, "R7 code", 64'(fault_code), 64'h09);

      // R8 unprivileged on supervisor block -> 0xD, privileged passes
      mem[48'h4000_1010] = 64'h8000_0401;
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b1, "R8 perm");
      chk(fault_code == 6'h0D, "R8 code", 64'(fault_code), 64'h0D);
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b0, "R8 priv ok");

      // R8 priority: wide address beats access bit
      mem[48'h4000_1010] = 64'h0100_8000_0001;
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b1, "R8 priority");
      chk(fault_code == 6'h01, "R8 asize first", 64'(fault_code), 64'h01);

      // R5 block type at level 0 and at level 3
      mem.delete();
      mem[48'h4000_0000] = 64'h4000_1401;
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b0, "R5 blk L0");
      chk(fault_code == 6'h04, "R5 L0", 64'(fault_code), 64'h04);
      chain4k(48'h4000_0000, 64'h9000_0441);
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b0, "R5 blk L3");
      chk(fault_code == 6'h07, "R5 L3", 64'(fault_code), 64'h07);

      // R6 wide next-table address at level 2
      chain4k(48'h4000_0000, 64'h9000_0443);
      mem[48'h4000_2000] = 64'h1000_4000_3003;
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b0, "R6 asize L2");
      chk(fault_code == 6'h02, "R6 code", 64'(fault_code), 64'h02);

      // R10 stray response while idle is ignored
      inject_spur = 1'b1;
      repeat (3) @(negedge clk);
      inject_spur = 1'b0;
      cyc = 0;
      repeat (3) begin
         @(negedge clk);
         if (done) cyc++;
      end
      chk(cyc == 0, "R10 stray rsp", 64'(cyc), 64'd0);
      chk(fault_code == 6'h02, "R10 result held", 64'(fault_code), 64'h02);
      chain4k(48'h4000_0000, 64'h9000_0443);
      run_walk(48'h8000_0000, 48'h4000_0000, 1'b0, 16, 1'b0, "R10 after stray");

      for (int i = 0; i < 300; i++) gen_trial();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule